// File: doc/BRIEF.md
# Ethernet receive frame status generator

This block watches one received Ethernet frame at a time as a byte stream and produces a 32-bit status word when the frame is complete. Each byte arrives with a valid qualifier. A start marker flags the first byte and an end marker flags the last byte. The block counts the bytes and decodes the destination address and the length/type field. It runs a CRC-32 over every byte, including the trailing four-byte frame check sequence. It also collects error conditions reported alongside the stream: receive errors, a late collision, leftover dribble bits and the outcome of an external address filter.

The status word and a one-cycle valid pulse appear on the clock after the last byte. Several flags qualify one another. A summary error bit gathers the serious errors. The CRC flag is suppressed when it cannot be trusted, and the dribble flag is suppressed after a late collision. Byte-count thresholds mark runt, oversize and watchdog frames. A downstream FIFO or host interface stores the word; that storage is not part of this block.

Top module: `rx_status_gen`

## Requirements
- R1: The status word and a one-cycle `status_vld_o` pulse appear on the clock after the byte that carries `eof_i`. Bits 29:16 hold the frame's byte count, including the FCS, saturating at 16383. Bits 31, 14, 9:8 and 0 are always zero. After reset the output is zero with no valid pulse.
- R2: A byte counts only when `byte_vld_i` is high. A frame starts on a byte that has `sof_i` set. Bytes after an end marker and before the next start are ignored, together with any `rx_err_i` or `late_col_i` on them. All collected state restarts on each start byte.
- R3: The CRC uses the reflected polynomial 0xEDB88320 with initial value 0xFFFFFFFF and runs over all frame bytes. The FCS is sent least significant byte first. A frame whose final register value is not 0xDEBB20E3 sets bit 1.
- R4: Bit 3 is set when `rx_err_i` is high on any byte of the frame. Bit 1 is then also set, even if the CRC is correct.
- R5: Bit 1 is forced to zero when the frame is a runt (bit 11), has a late collision (bit 6) or hits the watchdog (bit 4).
- R6: Bit 11 (runt) is set when the count is below 64. Bit 7 (too long) is set when the count exceeds 1518. Bit 4 (watchdog) is set when the count exceeds 2048. No bytes are dropped in any of these cases.
- R7: Bit 15 equals the OR of bits 11, 7, 6 and 1.
- R8: Bit 6 is set when `late_col_i` is high on any byte of the frame.
- R9: Bit 2 (dribble) uses `dribble_bits_i` and `mode_10m_i` as sampled on the last byte. When `mode_10m_i` is 0 (MII mode), the bit is set only for exactly 4 leftover bits. When `mode_10m_i` is 1 (10 Mbps mode), it is set for 3 or more leftover bits. It is never set when bit 6 is set.
- R10: Bit 13 (broadcast) is set when destination bytes 0..5 are all 0xFF. Bit 10 (multicast) is set when bit 0 of byte 0 is 1 and the address is not broadcast. Both bits need at least 6 bytes in the frame.
- R11: Bit 5 (frame type) is set when the count is at least 14 and the big-endian value of bytes 12..13 exceeds 1500.
- R12: Bit 12 (length error) is evaluated only when the count is at least 18 and the length/type value is at most 1500. It is set when count minus 18 differs from the larger of the length/type value and 46.
- R13: Bit 30 (filter fail) copies `filt_fail_i` as sampled on the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Byte qualifier |
| sof_i | input | 1 | First byte of a frame |
| eof_i | input | 1 | Last byte of a frame |
| byte_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Receive error on this byte |
| late_col_i | input | 1 | Late collision on this byte |
| dribble_bits_i | input | 3 | Leftover bits after the last byte |
| mode_10m_i | input | 1 | 1 = 10 Mbps mode, 0 = MII mode |
| filt_fail_i | input | 1 | Address filter rejected the frame |
| status_o | output | 32 | Frame status word |
| status_vld_o | output | 1 | Status valid, one cycle |

## Verification
The assertions check, on every valid pulse, the relations between the flags in the word. These are the summary OR, CRC suppression under runt, late-collision and watchdog frames, the dribble veto, mutual exclusion of broadcast and multicast, the runt and frame-type rules against the length field, and the one-cycle latency from the last byte. They also check that the byte counter advances on every in-frame byte. Only the bench scenarios can show that the CRC residue, the destination and length/type decoding, and the length-error arithmetic give the right values. The same holds for the MII and 10 Mbps dribble thresholds, the 1518 and 2048 boundaries, and the rule that bytes between frames are ignored.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  localparam int LEN_W       = 14;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
  localparam int DA_BYTES    = 6;
  localparam int LT_HI_POS   = 12;
  localparam int HDR_BYTES   = 14;
  localparam int OVH_BYTES   = 18;

  // status word bit positions
  localparam int B_FFAIL = 30;
  localparam int B_LEN_LO = 16;
  localparam int B_ESUM  = 15;
  localparam int B_BCAST = 13;
  localparam int B_LERR  = 12;
  localparam int B_RUNT  = 11;
  localparam int B_MCAST = 10;
  localparam int B_TLONG = 7;
  localparam int B_LCOL  = 6;
  localparam int B_FTYPE = 5;
  localparam int B_WDOG  = 4;
  localparam int B_RXERR = 3;
  localparam int B_DRIB  = 2;
  localparam int B_CRCE  = 1;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) r = (r[0] ^ d[k]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rx_frame_track.sv
module rx_frame_track
  import rx_status_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [7:0]       byte_i,
  output logic             act_o,
  output logic             first_o,
  output logic             last_o,
  output logic [LEN_W-1:0] len_nx_o,
  output logic [15:0]      lt_nx_o,
  output logic             bc_nx_o,
  output logic             mc_nx_o
);
  localparam logic [LEN_W-1:0] DA_END = LEN_W'(DA_BYTES);
  localparam logic [LEN_W-1:0] LT_HI  = LEN_W'(LT_HI_POS);
  localparam logic [LEN_W-1:0] LT_LO  = LEN_W'(LT_HI_POS + 1);

  logic             in_frame_q;
  logic [LEN_W-1:0] cnt_q, pos;
  logic [15:0]      lt_q, lt_base;
  logic             bc_q, mc_q, bc_base, mc_base;

  assign first_o = byte_vld_i & sof_i;
  assign act_o   = byte_vld_i & (sof_i | in_frame_q);
  assign last_o  = act_o & eof_i;
  assign pos     = first_o ? '0 : cnt_q;

  always_comb begin
    len_nx_o = cnt_q;
    if (first_o)    len_nx_o = LEN_W'(1);
    else if (act_o) len_nx_o = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

    bc_base = first_o ? 1'b1 : bc_q;
    mc_base = first_o ? 1'b0 : mc_q;
    lt_base = first_o ? 16'h0 : lt_q;
    bc_nx_o = bc_base;
    mc_nx_o = mc_base;
    lt_nx_o = lt_base;
    if (act_o) begin
      if (pos < DA_END) bc_nx_o = bc_base & (&byte_i);
      if (pos == '0)    mc_nx_o = byte_i[0];
      if (pos == LT_HI) lt_nx_o = {byte_i, lt_base[7:0]};
      if (pos == LT_LO) lt_nx_o = {lt_base[15:8], byte_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      lt_q       <= '0;
      bc_q       <= 1'b0;
      mc_q       <= 1'b0;
    end else begin
      if (act_o) in_frame_q <= ~eof_i;
      cnt_q <= len_nx_o;
      lt_q  <= lt_nx_o;
      bc_q  <= bc_nx_o;
      mc_q  <= mc_nx_o;
    end
  end

  // R2
  cnt_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !first_o && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R2
  sof_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |=> (cnt_q == LEN_W'(1)));
endmodule

// File: rtl/rx_crc32.sv
module rx_crc32
  import rx_status_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       first_i,
  input  logic [7:0] byte_i,
  output logic       crc_ok_nx_o
);
  logic [31:0] crc_q, crc_nx;

  always_comb begin
    crc_nx = crc_q;
    if (act_i) crc_nx = crc_step(first_i ? 32'hFFFF_FFFF : crc_q, byte_i);
  end

  assign crc_ok_nx_o = (crc_nx == CRC_RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= 32'hFFFF_FFFF;
    else         crc_q <= crc_nx;
  end
endmodule

// File: rtl/rx_status_word.sv
module rx_status_word
  import rx_status_pkg::*;
#(
  parameter int MIN_LEN     = 64,
  parameter int MAX_LEN     = 1518,
  parameter int WDOG_LEN    = 2048,
  parameter int TYPE_MAX    = 1500,
  parameter int MIN_PAYLOAD = 46
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [LEN_W-1:0] len_nx_i,
  input  logic [15:0]      lt_nx_i,
  input  logic             bc_nx_i,
  input  logic             mc_nx_i,
  input  logic             crc_ok_i,
  input  logic             rx_err_i,
  input  logic             late_col_i,
  input  logic [2:0]       dribble_bits_i,
  input  logic             mode_10m_i,
  input  logic             filt_fail_i,
  output logic [31:0]      status_o,
  output logic             status_vld_o
);
  localparam logic [LEN_W-1:0] L_MIN  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] L_MAX  = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] L_WDOG = LEN_W'(WDOG_LEN);
  localparam logic [LEN_W-1:0] L_DA   = LEN_W'(DA_BYTES);
  localparam logic [LEN_W-1:0] L_HDR  = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] L_OVH  = LEN_W'(OVH_BYTES);
  localparam logic [15:0]      T_MAX  = 16'(TYPE_MAX);
  localparam logic [15:0]      T_PAD  = 16'(MIN_PAYLOAD);

  logic        err_q, col_q, err_nx, col_nx;
  logic        runt, tlong, wdog, ftype, lerr, drib, crce, esum, bc, mc;
  logic [16:0] payload, want;
  logic [31:0] word;

  always_comb begin
    err_nx = err_q;
    col_nx = col_q;
    if (act_i) begin
      err_nx = (first_i ? 1'b0 : err_q) | rx_err_i;
      col_nx = (first_i ? 1'b0 : col_q) | late_col_i;
    end
  end

  always_comb begin
    runt    = len_nx_i < L_MIN;
    tlong   = len_nx_i > L_MAX;
    wdog    = len_nx_i > L_WDOG;
    ftype   = (len_nx_i >= L_HDR) && (lt_nx_i > T_MAX);
    payload = {3'b0, len_nx_i} - {3'b0, L_OVH};
    want    = {1'b0, (lt_nx_i < T_PAD) ? T_PAD : lt_nx_i};
    lerr    = (len_nx_i >= L_OVH) && (lt_nx_i <= T_MAX) && (payload != want);
    bc      = (len_nx_i >= L_DA) && bc_nx_i;
    mc      = (len_nx_i >= L_DA) && mc_nx_i && !bc_nx_i;
    drib    = (mode_10m_i ? (dribble_bits_i >= 3'd3) : (dribble_bits_i == 3'd4)) && !col_nx;
    crce    = (!crc_ok_i || err_nx) && !(runt || col_nx || wdog);
    esum    = runt | tlong | col_nx | crce;

    word           = '0;
    word[B_FFAIL]  = filt_fail_i;
    word[B_LEN_LO +: LEN_W] = len_nx_i;
    word[B_ESUM]   = esum;
    word[B_BCAST]  = bc;
    word[B_LERR]   = lerr;
    word[B_RUNT]   = runt;
    word[B_MCAST]  = mc;
    word[B_TLONG]  = tlong;
    word[B_LCOL]   = col_nx;
    word[B_FTYPE]  = ftype;
    word[B_WDOG]   = wdog;
    word[B_RXERR]  = err_nx;
    word[B_DRIB]   = drib;
    word[B_CRCE]   = crce;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q        <= 1'b0;
      col_q        <= 1'b0;
      status_o     <= '0;
      status_vld_o <= 1'b0;
    end else begin
      err_q        <= err_nx;
      col_q        <= col_nx;
      status_vld_o <= last_i;
      if (last_i) status_o <= word;
    end
  end

  // R1
  vld_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> status_vld_o);
  // R1
  vld_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> !status_vld_o);
  // R5
  crc_sup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_vld_o && (status_o[B_RUNT] || status_o[B_LCOL] || status_o[B_WDOG])) |-> !status_o[B_CRCE]);
  // R9
  drib_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_vld_o && status_o[B_LCOL]) |-> !status_o[B_DRIB]);
  // R10
  bc_mc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> !(status_o[B_BCAST] && status_o[B_MCAST]));
  // R6
  runt_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> (status_o[B_RUNT] == (status_o[B_LEN_LO +: LEN_W] < L_MIN)));
  // R11
  ftype_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_vld_o && (status_o[B_LEN_LO +: LEN_W] < L_HDR)) |-> !status_o[B_FTYPE]);
  // R4
  rxerr_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_vld_o && status_o[B_RXERR] && !status_o[B_RUNT] && !status_o[B_LCOL] && !status_o[B_WDOG])
      |-> status_o[B_CRCE]);
endmodule

// File: rtl/rx_status_gen.sv
module rx_status_gen
  import rx_status_pkg::*;
#(
  parameter int MIN_LEN     = 64,
  parameter int MAX_LEN     = 1518,
  parameter int WDOG_LEN    = 2048,
  parameter int TYPE_MAX    = 1500,
  parameter int MIN_PAYLOAD = 46
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_vld_i,
  input  logic        sof_i,
  input  logic        eof_i,
  input  logic [7:0]  byte_i,
  input  logic        rx_err_i,
  input  logic        late_col_i,
  input  logic [2:0]  dribble_bits_i,
  input  logic        mode_10m_i,
  input  logic        filt_fail_i,
  output logic [31:0] status_o,
  output logic        status_vld_o
);
  logic             act, first, last, bc_nx, mc_nx, crc_ok;
  logic [LEN_W-1:0] len_nx;
  logic [15:0]      lt_nx;

  rx_frame_track u_track (
    .clk_i, .rst_ni, .byte_vld_i, .sof_i, .eof_i, .byte_i,
    .act_o(act), .first_o(first), .last_o(last),
    .len_nx_o(len_nx), .lt_nx_o(lt_nx), .bc_nx_o(bc_nx), .mc_nx_o(mc_nx)
  );

  rx_crc32 u_crc (
    .clk_i, .rst_ni, .act_i(act), .first_i(first), .byte_i,
    .crc_ok_nx_o(crc_ok)
  );

  rx_status_word #(
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .WDOG_LEN(WDOG_LEN),
    .TYPE_MAX(TYPE_MAX), .MIN_PAYLOAD(MIN_PAYLOAD)
  ) u_word (
    .clk_i, .rst_ni, .act_i(act), .first_i(first), .last_i(last),
    .len_nx_i(len_nx), .lt_nx_i(lt_nx), .bc_nx_i(bc_nx), .mc_nx_i(mc_nx),
    .crc_ok_i(crc_ok), .rx_err_i, .late_col_i, .dribble_bits_i,
    .mode_10m_i, .filt_fail_i, .status_o, .status_vld_o
  );

  // R7
  err_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> (status_o[B_ESUM] ==
      (status_o[B_RUNT] | status_o[B_TLONG] | status_o[B_LCOL] | status_o[B_CRCE])));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> (!status_o[31] && !status_o[14] && (status_o[9:8] == 2'b00) && !status_o[0]));
endmodule

// File: tb/tb_rx_status_gen.sv
module tb_rx_status_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 0, sof = 0, eof = 0, rx_err = 0, late_col = 0, mode_10m = 0, filt_fail = 0;
  logic [7:0]  byte_d = 0;
  logic [2:0]  drib = 0;
  logic [31:0] status;
  logic        status_vld;

  int total = 0, bad = 0;
  logic [7:0] fq[$];
  bit         pend_vld = 0;
  logic [31:0] pend_word = 0;
  string      pend_tag = "";

  always #2.5 clk = ~clk;

  rx_status_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(byte_vld), .sof_i(sof), .eof_i(eof),
    .byte_i(byte_d), .rx_err_i(rx_err), .late_col_i(late_col), .dribble_bits_i(drib),
    .mode_10m_i(mode_10m), .filt_fail_i(filt_fail), .status_o(status), .status_vld_o(status_vld)
  );

  function automatic logic [31:0] crc_std(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, fq[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] model(input bit err, input bit col, input int d,
                                        input bit m10, input bit ff);
    int n = fq.size();
    int len = (n > 16383) ? 16383 : n;
    int lt = (n >= 14) ? (int'(fq[12]) * 256 + int'(fq[13])) : 0;
    bit runt = len < 64, tl = len > 1518, wd = len > 2048;
    bit crc_bad = 1, bc = 0, mc = 0, le = 0, ft, dr, ce;
    logic [31:0] w = 0;
    if (n >= 4) crc_bad = (crc_std(n - 4) != {fq[n-1], fq[n-2], fq[n-3], fq[n-4]});
    if (n >= 6) begin
      bc = (fq[0] == 8'hFF) && (fq[1] == 8'hFF) && (fq[2] == 8'hFF) &&
           (fq[3] == 8'hFF) && (fq[4] == 8'hFF) && (fq[5] == 8'hFF);
      mc = fq[0][0] && !bc;
    end
    ft = (n >= 14) && (lt > 1500);
    if (n >= 18 && lt <= 1500) le = ((len - 18) != ((lt < 46) ? 46 : lt));
    dr = (m10 ? (d >= 3) : (d == 4)) && !col;
    ce = (crc_bad || err) && !(runt || col || wd);
    w[30] = ff; w[29:16] = len[13:0]; w[15] = runt | tl | col | ce;
    w[13] = bc; w[12] = le; w[11] = runt; w[10] = mc; w[7] = tl; w[6] = col;
    w[5] = ft; w[4] = wd; w[3] = err; w[2] = dr; w[1] = ce;
    return w;
  endfunction

  task automatic tick();
    @(negedge clk);
    total++;
    if (status_vld !== pend_vld) begin
      bad++;
      $display("FAIL R1 valid pulse (%s): got %b exp %b", pend_tag, status_vld, pend_vld);
    end
    if (pend_vld) begin
      total++;
      if (status !== pend_word) begin
        bad++;
        $display("FAIL %s: status got %h exp %h", pend_tag, status, pend_word);
      end
    end
    pend_vld = 0;
  endtask

  task automatic drive_idle();
    byte_vld = 0; sof = 0; eof = 0; rx_err = 0; late_col = 0;
    drib = 0; filt_fail = 0; byte_d = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin tick(); drive_idle(); end
  endtask

  // da: 0 unicast, 1 broadcast, 2 multicast
  task automatic mk(input int n, input int da, input int lt, input bit bad_fcs);
    logic [31:0] c;
    int body = (n >= 4) ? n - 4 : n;
    fq.delete();
    for (int i = 0; i < body; i++) begin
      logic [7:0] b;
      if (i < 6)       b = (da == 1) ? 8'hFF : (i == 0) ? ((da == 2) ? 8'h01 : 8'h02) : 8'(8'h10 + i);
      else if (i < 12) b = 8'(8'hA0 + i);
      else if (i == 12) b = 8'(lt >> 8);
      else if (i == 13) b = 8'(lt);
      else             b = 8'(i * 7 + 3);
      fq.push_back(b);
    end
    if (n >= 4) begin
      c = crc_std(body);
      if (bad_fcs) c ^= 32'h1;
      fq.push_back(c[7:0]); fq.push_back(c[15:8]);
      fq.push_back(c[23:16]); fq.push_back(c[31:24]);
    end
  endtask

  task automatic send(input string tag, input int err_at, input int col_at, input int d,
                      input bit m10, input bit ff, input int stray);
    int n = fq.size();
    for (int i = 0; i < stray; i++) begin
      tick(); drive_idle();
      byte_vld = 1; byte_d = 8'h55; rx_err = 1; late_col = 1;
    end
    for (int i = 0; i < n; i++) begin
      tick(); drive_idle();
      byte_vld = 1; byte_d = fq[i]; sof = (i == 0); eof = (i == n - 1);
      rx_err = (i == err_at); late_col = (i == col_at);
      if (i == n - 1) begin
        drib = 3'(d); mode_10m = m10; filt_fail = ff;
        pend_vld = 1; pend_tag = tag;
        pend_word = model(err_at >= 0, col_at >= 0, d, m10, ff);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog expired: got hung exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (status !== 32'h0 || status_vld !== 1'b0) begin
      bad++; $display("FAIL R1 reset: got %h/%b exp 0/0", status, status_vld);
    end
    rst_n = 1;
    idle(2);
    mk(64, 0, 16'h0800, 0);   send("R1 R3 R11 good 64 ethII", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(100, 1, 16'h0800, 0);  send("R10 broadcast", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(64, 2, 46, 0);         send("R10 R12 multicast llc ok", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(80, 0, 100, 0);        send("R12 length mismatch", -1, -1, 0, 0, 0, 0);
    mk(64, 0, 20, 0);         send("R12 padded short llc back-to-back R2", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(40, 0, 16'h0800, 1);   send("R5 R6 R7 runt bad fcs", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(10, 1, 0, 0);          send("R11 short frame", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(63, 0, 16'h0800, 0);   send("R6 runt 63", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(1518, 0, 16'h0800, 0); send("R6 max 1518", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(1519, 0, 16'h0800, 0); send("R6 R7 too long 1519", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(2049, 0, 16'h0800, 1); send("R5 R6 watchdog 2049", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(2048, 0, 16'h0800, 1); send("R3 R6 2048 bad fcs", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(64, 0, 16'h0800, 0);   send("R4 rx error good crc", -1 + 30, -1, 0, 0, 0, 0);
    idle(1);
    mk(64, 0, 16'h0800, 1);   send("R8 R5 R9 late col", -1, 50, 4, 0, 0, 0);
    idle(1);
    mk(64, 0, 16'h0800, 0);   send("R9 mii 4", -1, -1, 4, 0, 0, 0);
    mk(64, 0, 16'h0800, 0);   send("R9 mii 3", -1, -1, 3, 0, 0, 0);
    mk(64, 0, 16'h0800, 0);   send("R9 10m 3", -1, -1, 3, 1, 0, 0);
    mk(64, 0, 16'h0800, 0);   send("R9 10m 2", -1, -1, 2, 1, 0, 0);
    idle(1);
    mk(64, 2, 16'h0800, 0);   send("R13 filter fail", -1, -1, 0, 0, 1, 0);
    idle(1);
    mk(64, 0, 16'h0800, 1);   send("R3 R7 bad crc", -1, -1, 0, 0, 0, 0);
    idle(1);
    mk(70, 0, 16'h0800, 0);   send("R2 stray bytes ignored", -1, -1, 0, 0, 0, 5);
    idle(1);
    mk(64, 0, 1500, 0);       send("R11 R12 lt 1500", -1, -1, 0, 0, 0, 0);
    mk(1519, 0, 1501, 0);     send("R11 lt 1501", -1, -1, 0, 0, 0, 0);
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule